// File: doc/BRIEF.md
# TDM Serial Stream Channel Interface

This block terminates one receive and one transmit line of a 2048 kb/s time-division serial link. The link clock runs at twice the bit rate, so every bit cell lasts two clock cycles. A 125 µs frame holds 32 channels of 8 bits, which is 512 clock cycles. An active-low frame pulse marks where a frame begins. The block counts its position inside the frame and serves only the four lowest channels. Channel 0 carries signalling data and channel 1 carries control data, and each of these two has its own enable input.

For each served channel, the block captures the transmit byte at the start of the channel and shifts it out MSB first. An output-enable signal stands in for a high-impedance line driver. In the other direction, the block collects received bits, sampled three quarters of the way into each cell, into a byte. It presents that byte with a one-cycle strobe. A one-hot strobe also marks the first cycle of each served channel for downstream logic. If a frame pulse is missing, the position counter keeps running. The next frame pulse that does arrive realigns the counter.

Top module: `tdm_chan_if`

## Requirements
- R1: When `fp_ni` is sampled low at a rising edge of `clk_i`, the cycle that follows is cycle 0 of the frame. Cycle t lies in channel t/16, bit cell t/2, and bit slot (t mod 16)/2.
- R2: With no frame pulse, the position wraps from cycle 511 back to cycle 0 and the channel timing repeats unchanged. A frame pulse arriving mid-frame realigns the timing at once.
- R3: For served channel c, the byte `tx_data_i[8c+7:8c]` is captured at the edge that starts the channel. `tx_o` carries its bit 7 in the first cell and its bit 0 in the last cell, and holds each bit for both cycles of the cell.
- R4: `tx_oe_o` is low in channels 4 to 31. `tx_o` is 0 whenever `tx_oe_o` is low.
- R5: In channel 0, `tx_oe_o` follows `d_en_i`. In channel 1, it follows `c_en_i`. Channels 2 and 3 are always enabled.
- R6: `rx_i` is sampled only at the falling edge of `clk_i` in the second cycle of each cell. Its value in the first cycle, and after that falling edge, has no effect.
- R7: For each served channel c, `rx_valid_o` is high for exactly cycle 16c+16. At that cycle, `rx_byte_o` holds the channel's bits, with the first bit received in bit 7, and `rx_ch_o` equals c. The enables have no effect on reception.
- R8: `ch_strobe_o[c]` is high in cycle 16c and in no other cycle, for c from 0 to 3.
- R9: After reset and before the first frame pulse, `tx_oe_o`, `ch_strobe_o` and `rx_valid_o` stay low.
- R10: While `rst_ni` is low, `tx_o`, `tx_oe_o`, `rx_valid_o` and `ch_strobe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_ni | input | 1 | Active-low frame pulse |
| rx_i | input | 1 | Receive serial stream |
| d_en_i | input | 1 | Enable for transmitting on channel 0 |
| c_en_i | input | 1 | Enable for transmitting on channel 1 |
| tx_data_i | input | 32 | Transmit bytes, channel c in bits 8c+7:8c |
| tx_o | output | 1 | Transmit serial stream |
| tx_oe_o | output | 1 | Transmit driver enable |
| rx_byte_o | output | 8 | Last received channel byte |
| rx_ch_o | output | 2 | Channel of `rx_byte_o` |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| ch_strobe_o | output | 4 | One-hot strobe marking the start of each served channel |

## Verification
The assertions check on every cycle that the transmit bit is steady within a cell and that the driver enable appears only in served and enabled channels. They also check that the channel strobes stay one-hot, that the receive strobe lasts one cycle and falls on a channel boundary, and that the counter responds to a frame pulse and wraps without one.

Only the bench scenarios can show the following:
- Bits actually travel MSB first and in the right slot.
- The receive sample lands at the three-quarter point. The bench drives the wrong value in the first half of each cell and again after the falling edge.
- Free-running frames keep their alignment.
- A frame pulse in the middle of a frame realigns the timing.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned DEF_NUM_CH  = 32;
  localparam int unsigned DEF_CH_BITS = 8;
  localparam int unsigned DEF_USED_CH = 4;
  // clock cycles per bit cell is fixed at two
  localparam int unsigned HALF_PER_BIT = 2;
  localparam int unsigned SIG_CH = 0;
  localparam int unsigned CTL_CH = 1;
endpackage

// File: rtl/tdm_timing.sv
module tdm_timing
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned CH_BITS = DEF_CH_BITS,
  localparam int unsigned FRAME_LEN = NUM_CH * CH_BITS * HALF_PER_BIT,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             locked_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  always_comb begin
    if (!fp_ni)            cnt_nx_o = '0;
    else if (cnt_o == LAST) cnt_nx_o = '0;
    else                   cnt_nx_o = cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      locked_o <= 1'b0;
    end else begin
      cnt_o <= cnt_nx_o;
      if (!fp_ni) locked_o <= 1'b1;
    end
  end

  a_r1_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> (cnt_o == '0) && locked_o);
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_ni && cnt_o == LAST) |=> (cnt_o == '0));
  a_r2_lock_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_pkg::*;
#(
  parameter int unsigned USED_CH = DEF_USED_CH,
  parameter int unsigned CH_BITS = DEF_CH_BITS,
  parameter int unsigned CNT_W   = 9,
  localparam int unsigned BIT_W  = $clog2(CH_BITS),
  localparam int unsigned CH_W   = CNT_W - BIT_W - 1,
  localparam int unsigned SEL_W  = $clog2(USED_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [CNT_W-1:0]           cnt_nx_i,
  input  logic                       locked_i,
  input  logic [USED_CH-1:0]         ch_en_i,
  input  logic [USED_CH*CH_BITS-1:0] tx_data_i,
  output logic                       tx_o,
  output logic                       tx_oe_o
);
  logic [CH_BITS-1:0] tx_bytes [USED_CH];
  logic [CH_BITS-1:0] tx_hold;
  logic [CH_W-1:0]    ch, ch_nx;
  logic [BIT_W-1:0]   slot;
  logic               load;

  for (genvar i = 0; i < USED_CH; i++) begin : g_bytes
    assign tx_bytes[i] = tx_data_i[i*CH_BITS +: CH_BITS];
  end

  assign ch    = cnt_i[CNT_W-1 -: CH_W];
  assign ch_nx = cnt_nx_i[CNT_W-1 -: CH_W];
  assign slot  = cnt_i[BIT_W:1];
  assign load  = (cnt_nx_i[BIT_W:0] == '0) && (ch_nx < CH_W'(USED_CH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tx_hold <= '0;
    else if (load) tx_hold <= tx_bytes[ch_nx[SEL_W-1:0]];
  end

  always_comb begin
    tx_oe_o = 1'b0;
    if (locked_i && ch < CH_W'(USED_CH)) tx_oe_o = ch_en_i[ch[SEL_W-1:0]];
  end

  assign tx_o = tx_oe_o & tx_hold[BIT_W'(CH_BITS - 1) - slot];

  a_r3_cell_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_oe_o && $past(tx_oe_o) && cnt_i[0]) |-> $stable(tx_o));
  a_r4_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> !tx_o);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_pkg::*;
#(
  parameter int unsigned USED_CH = DEF_USED_CH,
  parameter int unsigned CH_BITS = DEF_CH_BITS,
  parameter int unsigned CNT_W   = 9,
  localparam int unsigned BIT_W  = $clog2(CH_BITS),
  localparam int unsigned CH_W   = CNT_W - BIT_W - 1,
  localparam int unsigned SEL_W  = $clog2(USED_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               locked_i,
  input  logic               rx_i,
  output logic [CH_BITS-1:0] rx_byte_o,
  output logic [SEL_W-1:0]   rx_ch_o,
  output logic               rx_valid_o
);
  logic               rx_smp;
  logic [CH_BITS-1:0] shift_q;
  logic [CH_W-1:0]    ch;
  logic               last_cell;

  assign ch        = cnt_i[CNT_W-1 -: CH_W];
  assign last_cell = (cnt_i[BIT_W:0] == '1);

  // falling edge inside the second half-cell is the 3/4 point of the cell
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_smp <= 1'b0;
    else if (cnt_i[0]) rx_smp <= rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q    <= '0;
      rx_byte_o  <= '0;
      rx_ch_o    <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (cnt_i[0]) shift_q <= {shift_q[CH_BITS-2:0], rx_smp};
      if (cnt_i[0] && last_cell && locked_i && ch < CH_W'(USED_CH)) begin
        rx_byte_o  <= {shift_q[CH_BITS-2:0], rx_smp};
        rx_ch_o    <= ch[SEL_W-1:0];
        rx_valid_o <= 1'b1;
      end
    end
  end

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r7_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (cnt_i[BIT_W:0] == '0));
endmodule

// File: rtl/tdm_chan_if.sv
module tdm_chan_if
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned CH_BITS = DEF_CH_BITS,
  parameter int unsigned USED_CH = DEF_USED_CH,
  localparam int unsigned CNT_W  = $clog2(NUM_CH * CH_BITS * HALF_PER_BIT),
  localparam int unsigned BIT_W  = $clog2(CH_BITS),
  localparam int unsigned CH_W   = CNT_W - BIT_W - 1,
  localparam int unsigned SEL_W  = $clog2(USED_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fp_ni,
  input  logic                       rx_i,
  input  logic                       d_en_i,
  input  logic                       c_en_i,
  input  logic [USED_CH*CH_BITS-1:0] tx_data_i,
  output logic                       tx_o,
  output logic                       tx_oe_o,
  output logic [CH_BITS-1:0]         rx_byte_o,
  output logic [SEL_W-1:0]           rx_ch_o,
  output logic                       rx_valid_o,
  output logic [USED_CH-1:0]         ch_strobe_o
);
  logic [CNT_W-1:0]   cnt, cnt_nx;
  logic               locked;
  logic [USED_CH-1:0] ch_en;
  logic [CH_W-1:0]    ch;

  assign ch = cnt[CNT_W-1 -: CH_W];

  for (genvar i = 0; i < USED_CH; i++) begin : g_chan
    if (i == SIG_CH)      begin : g_sig assign ch_en[i] = d_en_i; end
    else if (i == CTL_CH) begin : g_ctl assign ch_en[i] = c_en_i; end
    else                  begin : g_on  assign ch_en[i] = 1'b1;   end
    assign ch_strobe_o[i] = locked && (cnt[BIT_W:0] == '0) && (ch == CH_W'(i));
  end

  tdm_timing #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_timing (
    .clk_i, .rst_ni, .fp_ni,
    .cnt_o(cnt), .cnt_nx_o(cnt_nx), .locked_o(locked)
  );

  tdm_tx #(.USED_CH(USED_CH), .CH_BITS(CH_BITS), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .cnt_i(cnt), .cnt_nx_i(cnt_nx), .locked_i(locked),
    .ch_en_i(ch_en), .tx_data_i, .tx_o, .tx_oe_o
  );

  tdm_rx #(.USED_CH(USED_CH), .CH_BITS(CH_BITS), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .cnt_i(cnt), .locked_i(locked), .rx_i,
    .rx_byte_o, .rx_ch_o, .rx_valid_o
  );

  a_r4_used_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> (ch < CH_W'(USED_CH)));
  a_r5_sig_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_oe_o && ch == CH_W'(SIG_CH)) |-> d_en_i);
  a_r5_ctl_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_oe_o && ch == CH_W'(CTL_CH)) |-> c_en_i);
  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_strobe_o));
  a_r9_idle_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (!tx_oe_o && ch_strobe_o == '0 && !rx_valid_o));
endmodule

// File: tb/tb_tdm_chan_if.sv
module tb_tdm_chan_if;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fp_ni = 1'b1;
  logic        rx_i = 1'b0;
  logic        d_en_i = 1'b0;
  logic        c_en_i = 1'b0;
  logic [31:0] tx_data_i;
  logic        tx_o, tx_oe_o, rx_valid_o;
  logic [7:0]  rx_byte_o;
  logic [1:0]  rx_ch_o;
  logic [3:0]  ch_strobe_o;

  logic [7:0] txd [4];
  logic [7:0] rxd [4];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign tx_data_i = {txd[3], txd[2], txd[1], txd[0]};

  always #4 clk = ~clk;

  tdm_chan_if dut (
    .clk_i(clk), .rst_ni, .fp_ni, .rx_i, .d_en_i, .c_en_i, .tx_data_i,
    .tx_o, .tx_oe_o, .rx_byte_o, .rx_ch_o, .rx_valid_o, .ch_strobe_o
  );

  task automatic chk(input string req, input int t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, t, act, exp);
    end
  endtask

  // entered and left at 6 ns after a rising edge
  task automatic run_frame(input bit use_fp);
    if (use_fp) fp_ni = 1'b0;
    for (int t = 0; t < 512; t++) begin
      int c = t / 16;
      int i = (t % 16) / 2;
      logic rbit;
      logic exp_oe, exp_tx;
      logic [3:0] exp_stb;
      @(posedge clk);
      #2;
      fp_ni = 1'b1;
      rbit = (c < 4) ? rxd[c][7-i] : logic'(t[2]);
      rx_i = (t % 2 == 0) ? ~rbit : rbit;  // R6: wrong value in first half-cell
      #4;
      exp_oe  = (c < 4) && ((c == 0) ? d_en_i : (c == 1) ? c_en_i : 1'b1);
      exp_tx  = exp_oe ? txd[c][7-i] : 1'b0;
      exp_stb = (t % 16 == 0 && c < 4) ? 4'(1 << c) : 4'h0;
      chk("R4/R5 oe", t, 32'(tx_oe_o), 32'(exp_oe));
      chk("R3 tx bit", t, 32'(tx_o), 32'(exp_tx));
      chk("R8 strobe", t, 32'(ch_strobe_o), 32'(exp_stb));
      if (t % 16 == 0 && t >= 16 && t <= 64) begin
        chk("R7 valid", t, 32'(rx_valid_o), 32'd1);
        chk("R7/R6 byte", t, 32'(rx_byte_o), 32'(rxd[c-1]));
        chk("R7 channel", t, 32'(rx_ch_o), 32'(c - 1));
      end else begin
        chk("R7 valid idle", t, 32'(rx_valid_o), 32'd0);
      end
      if (t % 2 == 1) rx_i = ~rbit;  // R6: wrong value after the falling edge
    end
  endtask

  task automatic set_pat(input int f, input bit d, input bit cc);
    for (int c = 0; c < 4; c++) begin
      txd[c] = 8'((f * 37 + c * 91 + 5) ^ (c << 5));
      rxd[c] = 8'((f * 53 + c * 29 + 11) ^ 8'h96);
    end
    d_en_i = d;
    c_en_i = cc;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_pat(0, 1, 1);
    repeat (3) @(posedge clk);
    #6;
    // R10
    chk("R10 reset tx", 0, 32'(tx_o), 0);
    chk("R10 reset oe", 0, 32'(tx_oe_o), 0);
    chk("R10 reset valid", 0, 32'(rx_valid_o), 0);
    chk("R10 reset strobe", 0, 32'(ch_strobe_o), 0);
    rst_ni = 1'b1;
    // R9: no frame pulse seen yet
    for (int k = 0; k < 600; k++) begin
      @(posedge clk);
      #6;
      chk("R9 oe before sync", k, 32'(tx_oe_o), 0);
      chk("R9 strobe before sync", k, 32'(ch_strobe_o), 0);
      chk("R9 valid before sync", k, 32'(rx_valid_o), 0);
    end
    // R1 aligned frames with various enables and data
    set_pat(1, 1, 1); run_frame(1);
    set_pat(2, 0, 1); run_frame(0);  // R2 free run
    set_pat(3, 1, 0); run_frame(1);
    set_pat(4, 0, 0); run_frame(0);  // R2
    txd = '{8'hFF, 8'h00, 8'hAA, 8'h55};
    rxd = '{8'h00, 8'hFF, 8'h55, 8'hAA};
    d_en_i = 1; c_en_i = 1;
    run_frame(1);
    txd = '{8'h80, 8'h01, 8'h7E, 8'hC3};
    rxd = '{8'h01, 8'h80, 8'h3C, 8'hE7};
    run_frame(0);
    // R2: realign from the middle of a frame
    repeat (37) @(posedge clk);
    #6;
    set_pat(7, 1, 1); run_frame(1);
    repeat (201) @(posedge clk);
    #6;
    set_pat(8, 0, 1); run_frame(1);
    set_pat(9, 1, 0); run_frame(0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule